// File: doc/BRIEF.md
# Self-Adapting N-Modular Redundancy Voter

This block sits behind a bank of identical redundant modules that all compute the same function on the same input. Each module hands over a p-bit result word, and the voter merges the words into one corrected output. It does more than a fixed majority vote. Whenever a module's word disagrees with the majority, that module is marked faulty. It then stays out of the vote until an external agent repairs it and clears the marks.

Because the voting population shrinks as modules are diagnosed, faults can pile up over time. The output stays correct for as long as a strict majority of the remaining healthy modules agree. When that is no longer true, an alarm output tells the system that the corrected word can no longer be trusted. The output, the per-module status flags and the alarm are all registered, with one clock of latency.

Top module: `nmr_adaptive_voter`

## Requirements
- R1: While the synchronous active-high reset is high, and on the first clock after it, the voted word is 0, all status flags are 0 and the alarm is 0.
- R2: When every healthy module presents the same word, the voted output equals that word one clock later, and no flag changes.
- R3: When a strict majority of the healthy modules (more than half of them) share one word, that word appears on the voted output one clock later. Bit i of the flag vector is set one clock later for every healthy module i whose word differs from it.
- R4: A set status flag stays set on later clocks, even when the module agrees with the majority again, until a clear is applied.
- R5: Modules whose flag is set take no part in the vote. The majority is counted only over modules with a clear flag, even when the flagged modules would outvote them.
- R6: When no word has a strict majority among the healthy modules, the alarm is 1 one clock later, the voted word keeps its previous value and no flag changes. This covers an even population that splits evenly, an odd population with no repeated word, and fewer than two healthy modules.
- R7: Raising the synchronous clear input for one clock makes all flags 0 on the next clock, so every module rejoins the vote.
- R8: The alarm returns to 0 one clock after a strict majority of at least two healthy modules exists again.
- R9: A module is judged on its whole p-bit word: a difference in a single bit is enough to flag it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_flags | input | 1 | Synchronous clear of all status flags after repair |
| mod_words | input | N_MOD*WIDTH | Result words; module i occupies bits [i*WIDTH +: WIDTH] |
| voted | output | WIDTH | Registered corrected word |
| err_flags | output | N_MOD | Registered sticky fault flag, bit i for module i |
| unmasked_fault | output | 1 | Registered alarm: no trustworthy majority in the last cycle |

## Verification
The bench chases the population as it shrinks. It corrupts one module at a time with single-bit and multi-bit differences and checks that the diagnosed modules stay out of the count. A design that still counted them would pick the minority word when flagged modules happen to agree with each other. Even splits of four and of two healthy modules, and five mutually different words, target the alarm-and-hold path. A design that broke ties by index would emit a guessed word and wrongly flag modules. A clear followed by a fresh corruption confirms that the repaired modules rejoin the vote. A mixed stretch of corrupted patterns is then compared every cycle against a behavioural counting model.

// File: rtl/nmr_pkg.sv
package nmr_pkg;
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/nmr_agree_unit.sv
module nmr_agree_unit #(
  parameter int N_MOD = 5,
  parameter int WIDTH = 8,
  parameter int CW    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_MOD*WIDTH-1:0]   mod_words,
  input  logic [N_MOD-1:0]         healthy,
  output logic [N_MOD-1:0][CW-1:0] agree_cnt
);
  for (genvar i = 0; i < N_MOD; i++) begin : g_row
    logic [N_MOD-1:0] match;
    for (genvar j = 0; j < N_MOD; j++) begin : g_col
      assign match[j] = healthy[j] &&
        (mod_words[i*WIDTH +: WIDTH] == mod_words[j*WIDTH +: WIDTH]);
    end
    always_comb begin
      agree_cnt[i] = '0;
      for (int k = 0; k < N_MOD; k++)
        agree_cnt[i] = agree_cnt[i] + CW'(match[k]);
    end
    // A healthy module always agrees at least with itself (R3)
    p_self_agree_r3: assert property (@(posedge clk) disable iff (rst)
      healthy[i] |-> (agree_cnt[i] != '0));
  end
endmodule

// File: rtl/nmr_majority_pick.sv
module nmr_majority_pick #(
  parameter int N_MOD = 5,
  parameter int CW    = 3,
  parameter int IW    = 3
) (
  input  logic [N_MOD-1:0][CW-1:0] agree_cnt,
  input  logic [N_MOD-1:0]         healthy,
  input  logic [CW-1:0]            pop,
  output logic                     found,
  output logic [IW-1:0]            sel
);
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = N_MOD - 1; i >= 0; i--) begin
      if (healthy[i] && (2 * int'(agree_cnt[i]) > int'(pop))) begin
        found = 1'b1;
        sel   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/nmr_adaptive_voter.sv
module nmr_adaptive_voter #(
  parameter int N_MOD = 5,
  parameter int WIDTH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr_flags,
  input  logic [N_MOD*WIDTH-1:0] mod_words,
  output logic [WIDTH-1:0]       voted,
  output logic [N_MOD-1:0]       err_flags,
  output logic                   unmasked_fault
);
  import nmr_pkg::*;
  localparam int CW = cnt_bits(N_MOD);
  localparam int IW = (N_MOD > 1) ? $clog2(N_MOD) : 1;

  logic [N_MOD-1:0]         healthy;
  logic [CW-1:0]            pop;
  logic [N_MOD-1:0][CW-1:0] agree_cnt;
  logic                     found;
  logic [IW-1:0]            sel;
  logic                     trusted;
  logic [WIDTH-1:0]         maj_word;
  logic [N_MOD-1:0]         dissent;

  assign healthy = ~err_flags;

  always_comb begin
    pop = '0;
    for (int k = 0; k < N_MOD; k++) pop = pop + CW'(healthy[k]);
  end

  nmr_agree_unit #(.N_MOD(N_MOD), .WIDTH(WIDTH), .CW(CW)) u_agree (
    .clk(clk), .rst(rst), .mod_words(mod_words),
    .healthy(healthy), .agree_cnt(agree_cnt));

  nmr_majority_pick #(.N_MOD(N_MOD), .CW(CW), .IW(IW)) u_pick (
    .agree_cnt(agree_cnt), .healthy(healthy), .pop(pop),
    .found(found), .sel(sel));

  assign trusted  = found && (int'(pop) >= 2);
  assign maj_word = mod_words[int'(sel)*WIDTH +: WIDTH];

  for (genvar i = 0; i < N_MOD; i++) begin : g_dis
    assign dissent[i] = healthy[i] && (mod_words[i*WIDTH +: WIDTH] != maj_word);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      voted          <= '0;
      err_flags      <= '0;
      unmasked_fault <= 1'b0;
    end else begin
      unmasked_fault <= !trusted;
      if (trusted) voted <= maj_word;
      if (clr_flags)    err_flags <= '0;
      else if (trusted) err_flags <= err_flags | dissent;
    end
  end

  // Flags never drop without a clear (R4)
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !clr_flags |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
  // Clear empties the flag vector (R7)
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr_flags |=> (err_flags == '0));
  // Alarm holds the output (R6)
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    unmasked_fault |-> $stable(voted));
  // No flag appears while the alarm is raised (R6)
  p_noflag_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_flags && !trusted) |=> $stable(err_flags));
  // Majority word never comes from a flagged module (R5)
  p_pick_healthy_r5: assert property (@(posedge clk) disable iff (rst)
    found |-> healthy[sel]);
endmodule

// File: tb/nmr_adaptive_voter_bench.sv
module nmr_adaptive_voter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           clr_flags = 1'b0;
  logic [N*W-1:0] mod_words = '0;
  logic [W-1:0]   voted;
  logic [N-1:0]   err_flags;
  logic           unmasked_fault;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] m_voted = '0;
  logic [N-1:0] m_flags = '0;
  logic         m_nmf   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmr_adaptive_voter #(.N_MOD(N), .WIDTH(W)) u_nmr_adaptive_voter (
    .clk(clk), .rst(rst), .clr_flags(clr_flags), .mod_words(mod_words),
    .voted(voted), .err_flags(err_flags), .unmasked_fault(unmasked_fault));

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_update(input logic [N*W-1:0] wd, input logic clr);
    int pop = 0;
    int best = -1;
    logic [W-1:0] mw;
    logic [N-1:0] nf;
    for (int i = 0; i < N; i++) if (!m_flags[i]) pop++;
    for (int i = 0; i < N; i++) begin
      int c = 0;
      if (m_flags[i]) continue;
      for (int j = 0; j < N; j++)
        if (!m_flags[j] && wd[j*W +: W] == wd[i*W +: W]) c++;
      if (best < 0 && 2 * c > pop) best = i;
    end
    nf = m_flags;
    if (best >= 0 && pop >= 2) begin
      mw = wd[best*W +: W];
      m_voted = mw;
      for (int i = 0; i < N; i++)
        if (!m_flags[i] && wd[i*W +: W] != mw) nf[i] = 1'b1;
      m_nmf = 1'b0;
    end else begin
      m_nmf = 1'b1;
    end
    m_flags = clr ? '0 : nf;
  endtask

  task automatic step(input logic [W-1:0] w0, input logic [W-1:0] w1,
                      input logic [W-1:0] w2, input logic [W-1:0] w3,
                      input logic [W-1:0] w4, input logic clr, input string req);
    mod_words = {w4, w3, w2, w1, w0};
    clr_flags = clr;
    @(posedge clk);
    model_update(mod_words, clr);
    @(negedge clk);
    check(req, int'(voted), int'(m_voted), "voted");
    check(req, int'(err_flags), int'(m_flags), "flags");
    check(req, int'(unmasked_fault), int'(m_nmf), "alarm");
    clr_flags = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", int'(voted), 0, "voted");
    check("R1", int'(err_flags), 0, "flags");
    check("R1", int'(unmasked_fault), 0, "alarm");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", int'(voted), 0, "voted after release");
    // R2: unanimous patterns
    step(8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 1'b0, "R2");
    check("R2", int'(voted), 8'h5A, "direct");
    step(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, "R2");
    step(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, "R2");
    // R9 + R3: single-bit difference on module 2
    step(8'h5A, 8'h5A, 8'h5B, 8'h5A, 8'h5A, 1'b0, "R9");
    check("R9", int'(err_flags), 5'b00100, "single-bit flag");
    check("R3", int'(voted), 8'h5A, "majority word");
    // R4: module 2 agrees again, flag stays
    step(8'h33, 8'h33, 8'h33, 8'h33, 8'h33, 1'b0, "R4");
    check("R4", int'(err_flags), 5'b00100, "sticky");
    // R3: module 0 deviates among four healthy
    step(8'h11, 8'h22, 8'h11, 8'h22, 8'h22, 1'b0, "R3");
    check("R3", int'(err_flags), 5'b00101, "flag module 0");
    // R5: flagged 0 and 2 side with module 1; healthy 3,4 outvote it
    step(8'h77, 8'h77, 8'h77, 8'h88, 8'h88, 1'b0, "R5");
    check("R5", int'(voted), 8'h88, "healthy-only majority");
    check("R5", int'(err_flags), 5'b00111, "flag module 1");
    // R6: two healthy split
    step(8'h88, 8'h88, 8'h88, 8'h01, 8'h02, 1'b0, "R6");
    check("R6", int'(unmasked_fault), 1, "tie alarm");
    check("R6", int'(voted), 8'h88, "tie hold");
    // R8: agreement returns
    step(8'h00, 8'h00, 8'h00, 8'h44, 8'h44, 1'b0, "R8");
    check("R8", int'(unmasked_fault), 0, "alarm drops");
    // R7: clear
    step(8'h44, 8'h44, 8'h44, 8'h44, 8'h44, 1'b1, "R7");
    check("R7", int'(err_flags), 0, "cleared");
    // R7: repaired modules vote again
    step(8'h66, 8'h66, 8'h66, 8'h66, 8'hE6, 1'b0, "R7");
    check("R7", int'(err_flags), 5'b10000, "rejoined");
    // R6: four healthy split 2-2
    step(8'h10, 8'h10, 8'h20, 8'h20, 8'h10, 1'b0, "R6");
    check("R6", int'(unmasked_fault), 1, "even split");
    step(8'h10, 8'h10, 8'h10, 8'h10, 8'h10, 1'b1, "R7");
    // R6: five distinct words
    step(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 1'b0, "R6");
    check("R6", int'(unmasked_fault), 1, "no majority");
    check("R6", int'(err_flags), 0, "no flags");
    // Mixed stretch against the model
    x = 8'h3C;
    for (int t = 0; t < 60; t++) begin
      logic [W-1:0] v [N];
      x = {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
      for (int i = 0; i < N; i++) v[i] = x;
      if (t % 3 == 0) v[t % N] = x ^ 8'h01;
      if (t % 7 == 0) v[(t + 2) % N] = ~x;
      step(v[0], v[1], v[2], v[3], v[4], (t % 17 == 16), "R3");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule